// File: doc/BRIEF.md
# Shared Code Memory Clock Controller

This block makes the control decisions for a code memory that two processing engines share. It watches a stop flag and a halt flag from each engine. It also holds three host-written control bits: a visibility bit, an integrity-check enable and a module-disable bit. From these it produces a registered clock enable for an external glitch-free clock gate. It also produces the run and reset controls for the memory's background integrity checker, whose address sequencer it contains.

Host writes arrive as one write strobe and one data bit per field. A guard qualifies each write. A visibility set is refused unless the engines are in a safe state. While visibility is set, a module-disable clear is refused, and the engines are held in stop whatever the external stop request.

Top module: `scm_clk_ctrl`

## Requirements
- R1: After reset, mem_clk_en_o is 1, and vis_o, chk_en_o, mdis_o and chk_addr_o are all 0.
- R2: mem_clk_en_o is 0 in the cycle after one in which both stop flags are 1, vis_o is 0 and chk_en_o is 0. After any other cycle it is 1 (one register of latency).
- R3: While either stop flag is 0, the memory clock stays enabled, even when both halt flags are 1.
- R4: chk_run_o is 1 exactly when chk_en_o is 1 and vis_o is 0.
- R5: chk_rst_o equals vis_o, so the integrity checker is held in reset for the whole time visibility is set.
- R6: A visibility write of 1 is accepted (vis_wr_ok_o = 1, and vis_o becomes 1 at the next edge) only if both stop flags are 1 or at least one halt flag is 1. Otherwise it is refused and vis_o is unchanged. A visibility write of 0 is always accepted.
- R7: While vis_o is 1, a module-disable write of 0 is refused (mdis_wr_ok_o = 0, mdis_o unchanged). A module-disable write of 1 is always accepted.
- R8: eng_stop_req_o is the external stop request OR vis_o, so engines cannot leave stop while visibility is set.
- R9: chk_addr_o is cleared to 0 at every edge where vis_o is 1. It steps by one at every edge where chk_run_o is 1, and after MEM_WORDS-1 it goes to 0. Otherwise it holds.
- R10: An integrity-check enable write is always accepted, and chk_en_o takes the written value at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stop_a_i | input | 1 | Engine A stopped |
| stop_b_i | input | 1 | Engine B stopped |
| halt_a_i | input | 1 | Engine A halted |
| halt_b_i | input | 1 | Engine B halted |
| stop_req_i | input | 1 | External stop request toward the engines |
| vis_we_i | input | 1 | Host write strobe, visibility bit |
| vis_wd_i | input | 1 | Host write data, visibility bit |
| chk_en_we_i | input | 1 | Host write strobe, integrity-check enable |
| chk_en_wd_i | input | 1 | Host write data, integrity-check enable |
| mdis_we_i | input | 1 | Host write strobe, module-disable bit |
| mdis_wd_i | input | 1 | Host write data, module-disable bit |
| vis_o | output | 1 | Visibility bit |
| chk_en_o | output | 1 | Integrity-check enable bit |
| mdis_o | output | 1 | Module-disable bit |
| vis_wr_ok_o | output | 1 | Current visibility write is accepted |
| mdis_wr_ok_o | output | 1 | Current module-disable write is accepted |
| mem_clk_en_o | output | 1 | Registered memory clock enable |
| chk_run_o | output | 1 | Integrity checker runs |
| chk_rst_o | output | 1 | Integrity checker held in reset |
| chk_addr_o | output | $clog2(MEM_WORDS) | Integrity checker address |
| eng_stop_req_o | output | 1 | Stop request to the engines |

## Verification
Two functions can fall in the same cycle. A visibility write can land together with a stop flag or a halt flag falling, and a module-disable clear can arrive while visibility is being set or cleared. In both cases the guard must judge the write against the state before the edge. Random stimulus with stop flags biased high makes these overlaps common. Directed cases set visibility while the engines are halted but not stopped, and then try a module-disable clear in the cycle where visibility is written to 0. A bench model updates every register from pre-edge values and judges each qualifier and output against it.

// File: rtl/scm_pkg.sv
package scm_pkg;
  typedef struct packed {
    logic we;
    logic wd;
  } fld_wr_t;
endpackage

// File: rtl/scm_host_regs.sv
module scm_host_regs
  import scm_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    eng_safe_i,
  input  fld_wr_t vis_wr_i,
  input  fld_wr_t en_wr_i,
  input  fld_wr_t mdis_wr_i,
  output logic    vis_ok_o,
  output logic    mdis_ok_o,
  output logic    vis_q_o,
  output logic    en_q_o,
  output logic    mdis_q_o
);
  logic vis_q, en_q, mdis_q;

  // set needs safe engines; clear is free
  assign vis_ok_o  = vis_wr_i.we & (~vis_wr_i.wd | eng_safe_i);
  // clear blocked while visible
  assign mdis_ok_o = mdis_wr_i.we & (mdis_wr_i.wd | ~vis_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vis_q  <= 1'b0;
      en_q   <= 1'b0;
      mdis_q <= 1'b0;
    end else begin
      if (vis_ok_o)  vis_q  <= vis_wr_i.wd;
      if (en_wr_i.we) en_q  <= en_wr_i.wd;
      if (mdis_ok_o) mdis_q <= mdis_wr_i.wd;
    end
  end

  assign vis_q_o  = vis_q;
  assign en_q_o   = en_q;
  assign mdis_q_o = mdis_q;
endmodule

// File: rtl/scm_clk_gate_ctl.sv
module scm_clk_gate_ctl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic stop_a_i,
  input  logic stop_b_i,
  input  logic vis_i,
  input  logic en_i,
  output logic clk_en_o
);
  logic off_req;
  logic clk_en_q;

  assign off_req = stop_a_i & stop_b_i & ~vis_i & ~en_i;

  // registered so the external gate sees a clean level
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) clk_en_q <= 1'b1;
    else         clk_en_q <= ~off_req;
  end

  assign clk_en_o = clk_en_q;
endmodule

// File: rtl/scm_chk_seq.sv
module scm_chk_seq #(
  parameter int MEM_WORDS = 256,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          run_i,
  input  logic          clr_i,
  output logic [AW-1:0] addr_o
);
  localparam logic [AW-1:0] LastAddr = AW'(MEM_WORDS - 1);
  logic [AW-1:0] addr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                addr_q <= '0;
    else if (clr_i)             addr_q <= '0;
    else if (run_i) begin
      if (addr_q == LastAddr)   addr_q <= '0;
      else                      addr_q <= addr_q + 1'b1;
    end
  end

  assign addr_o = addr_q;
endmodule

// File: rtl/scm_clk_ctrl.sv
module scm_clk_ctrl
  import scm_pkg::*;
#(
  parameter int MEM_WORDS = 256,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          stop_a_i,
  input  logic          stop_b_i,
  input  logic          halt_a_i,
  input  logic          halt_b_i,
  input  logic          stop_req_i,
  input  logic          vis_we_i,
  input  logic          vis_wd_i,
  input  logic          chk_en_we_i,
  input  logic          chk_en_wd_i,
  input  logic          mdis_we_i,
  input  logic          mdis_wd_i,
  output logic          vis_o,
  output logic          chk_en_o,
  output logic          mdis_o,
  output logic          vis_wr_ok_o,
  output logic          mdis_wr_ok_o,
  output logic          mem_clk_en_o,
  output logic          chk_run_o,
  output logic          chk_rst_o,
  output logic [AW-1:0] chk_addr_o,
  output logic          eng_stop_req_o
);
  fld_wr_t vis_wr, en_wr, mdis_wr;
  logic    eng_safe;
  logic    vis_q, en_q;

  assign vis_wr  = '{we: vis_we_i,    wd: vis_wd_i};
  assign en_wr   = '{we: chk_en_we_i, wd: chk_en_wd_i};
  assign mdis_wr = '{we: mdis_we_i,   wd: mdis_wd_i};

  // both stopped, or at least one halted
  assign eng_safe = (stop_a_i & stop_b_i) | halt_a_i | halt_b_i;

  scm_host_regs u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .eng_safe_i (eng_safe),
    .vis_wr_i   (vis_wr),
    .en_wr_i    (en_wr),
    .mdis_wr_i  (mdis_wr),
    .vis_ok_o   (vis_wr_ok_o),
    .mdis_ok_o  (mdis_wr_ok_o),
    .vis_q_o    (vis_q),
    .en_q_o     (en_q),
    .mdis_q_o   (mdis_o)
  );

  scm_clk_gate_ctl u_gate (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .stop_a_i (stop_a_i),
    .stop_b_i (stop_b_i),
    .vis_i    (vis_q),
    .en_i     (en_q),
    .clk_en_o (mem_clk_en_o)
  );

  assign chk_run_o = en_q & ~vis_q;
  assign chk_rst_o = vis_q;

  scm_chk_seq #(.MEM_WORDS(MEM_WORDS)) u_seq (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (chk_run_o),
    .clr_i  (vis_q),
    .addr_o (chk_addr_o)
  );

  assign eng_stop_req_o = stop_req_i | vis_q;
  assign vis_o    = vis_q;
  assign chk_en_o = en_q;
endmodule

// File: rtl/scm_clk_ctrl_chk.sv
module scm_clk_ctrl_chk #(
  parameter int MEM_WORDS = 256,
  localparam int AW = $clog2(MEM_WORDS)
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          stop_a_i,
  input logic          stop_b_i,
  input logic          halt_a_i,
  input logic          halt_b_i,
  input logic          stop_req_i,
  input logic          mdis_we_i,
  input logic          mdis_wd_i,
  input logic          vis_o,
  input logic          chk_en_o,
  input logic          mdis_o,
  input logic          mem_clk_en_o,
  input logic          chk_run_o,
  input logic          chk_rst_o,
  input logic [AW-1:0] chk_addr_o,
  input logic          eng_stop_req_o
);
  a_r2_clk_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stop_a_i && stop_b_i && !vis_o && !chk_en_o) |=> !mem_clk_en_o);

  a_r3_clk_on: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!stop_a_i || !stop_b_i) |=> mem_clk_en_o);

  a_r4_run_excl: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_run_o |-> !chk_rst_o);

  a_r6_vis_guard: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(vis_o) |-> $past((stop_a_i && stop_b_i) || halt_a_i || halt_b_i));

  a_r7_mdis_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (vis_o && mdis_we_i && !mdis_wd_i) |=> $stable(mdis_o));

  a_r8_stop_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vis_o |-> eng_stop_req_o);

  a_r9_addr_clr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    chk_rst_o |=> (chk_addr_o == '0));
endmodule

bind scm_clk_ctrl scm_clk_ctrl_chk #(.MEM_WORDS(MEM_WORDS)) chk_i (.*);

// File: tb/scm_clk_ctrl_tb_top.sv
module scm_clk_ctrl_tb_top;
  localparam int MEM_WORDS = 256;
  localparam int AW = $clog2(MEM_WORDS);

  logic clk = 1'b0, rst_n = 1'b0;
  logic stop_a = 0, stop_b = 0, halt_a = 0, halt_b = 0, stop_req = 0;
  logic vis_we = 0, vis_wd = 0, en_we = 0, en_wd = 0, mdis_we = 0, mdis_wd = 0;
  logic vis, chk_en, mdis, vis_ok, mdis_ok, clk_en, run, crst, estop;
  logic [AW-1:0] addr;

  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // model state
  bit m_vis, m_en, m_mdis, m_clk;
  int m_addr;

  always #4 clk = ~clk;

  scm_clk_ctrl #(.MEM_WORDS(MEM_WORDS)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .stop_a_i(stop_a), .stop_b_i(stop_b), .halt_a_i(halt_a), .halt_b_i(halt_b),
    .stop_req_i(stop_req),
    .vis_we_i(vis_we), .vis_wd_i(vis_wd), .chk_en_we_i(en_we), .chk_en_wd_i(en_wd),
    .mdis_we_i(mdis_we), .mdis_wd_i(mdis_wd),
    .vis_o(vis), .chk_en_o(chk_en), .mdis_o(mdis),
    .vis_wr_ok_o(vis_ok), .mdis_wr_ok_o(mdis_ok), .mem_clk_en_o(clk_en),
    .chk_run_o(run), .chk_rst_o(crst), .chk_addr_o(addr), .eng_stop_req_o(estop)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic bit f_safe(bit sa, bit sb, bit ha, bit hb);
    return (sa & sb) | ha | hb;
  endfunction

  function automatic bit f_clk_next(bit sa, bit sb, bit v, bit e);
    return !(sa & sb & !v & !e);
  endfunction

  // combinational checks, inputs settled, before edge
  task automatic check_comb();
    bit exp_vok, exp_mok;
    exp_vok = vis_we & (!vis_wd | f_safe(stop_a, stop_b, halt_a, halt_b));
    exp_mok = mdis_we & (mdis_wd | !m_vis);
    check(vis_ok == exp_vok, "R6 vis_wr_ok", vis_ok, exp_vok);
    check(mdis_ok == exp_mok, "R7 mdis_wr_ok", mdis_ok, exp_mok);
    check(run == (m_en & !m_vis), "R4 chk_run", run, m_en & !m_vis);
    check(crst == m_vis, "R5 chk_rst", crst, m_vis);
    check(estop == (stop_req | m_vis), "R8 eng_stop_req", estop, stop_req | m_vis);
  endtask

  task automatic step_model();
    bit nv, ne, nm, nc;
    int na;
    nv = m_vis; ne = m_en; nm = m_mdis;
    if (vis_we && (!vis_wd || f_safe(stop_a, stop_b, halt_a, halt_b))) nv = vis_wd;
    if (en_we) ne = en_wd;
    if (mdis_we && (mdis_wd || !m_vis)) nm = mdis_wd;
    nc = f_clk_next(stop_a, stop_b, m_vis, m_en);
    na = m_addr;
    if (m_vis) na = 0;
    else if (m_en) na = (m_addr == MEM_WORDS - 1) ? 0 : m_addr + 1;
    m_vis = nv; m_en = ne; m_mdis = nm; m_clk = nc; m_addr = na;
  endtask

  task automatic check_regs();
    check(vis == m_vis, "R6 vis_o", vis, m_vis);
    check(chk_en == m_en, "R10 chk_en_o", chk_en, m_en);
    check(mdis == m_mdis, "R7 mdis_o", mdis, m_mdis);
    check(clk_en == m_clk, "R2 mem_clk_en", clk_en, m_clk);
    check(int'(addr) == m_addr, "R9 chk_addr", addr, m_addr);
  endtask

  // inputs are driven at negedge by caller; this finishes the cycle
  task automatic cycle();
    #1 check_comb();
    @(posedge clk);
    step_model();
    #1 check_regs();
    @(negedge clk);
  endtask

  task automatic idle_wr();
    vis_we = 0; en_we = 0; mdis_we = 0;
  endtask

  initial begin
    #2000000;
    n_fail++;
    $display("FAIL watchdog actual=0 expected=1");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    void'($urandom(32'h5c0de));
    repeat (3) @(negedge clk);
    // R1 reset state
    check(clk_en == 1'b1, "R1 mem_clk_en", clk_en, 1);
    check(vis == 0 && chk_en == 0 && mdis == 0, "R1 regs", {vis, chk_en, mdis}, 0);
    check(addr == 0, "R1 chk_addr", addr, 0);
    rst_n = 1'b1;
    m_vis = 0; m_en = 0; m_mdis = 0; m_clk = 1; m_addr = 0;
    @(negedge clk);

    // R3: both halted, not stopped -> clock stays on
    stop_a = 0; stop_b = 1; halt_a = 1; halt_b = 1;
    repeat (3) cycle();
    check(clk_en == 1'b1, "R3 halted not stopped", clk_en, 1);

    // R2: both stopped, all clear -> off, then on when one stop clears
    stop_a = 1; stop_b = 1; halt_a = 0; halt_b = 0;
    cycle(); cycle();
    check(clk_en == 1'b0, "R2 clock off", clk_en, 0);
    stop_b = 0; cycle();
    check(clk_en == 1'b1, "R2 clock back on", clk_en, 1);

    // R6 refused: one engine running, no halt
    vis_we = 1; vis_wd = 1; cycle(); idle_wr();
    check(vis == 1'b0, "R6 set refused", vis, 0);
    // R6 accepted via halt
    halt_a = 1; vis_we = 1; vis_wd = 1; cycle(); idle_wr();
    check(vis == 1'b1, "R6 set via halt", vis, 1);
    // R7: mdis set, then clear refused while visible
    mdis_we = 1; mdis_wd = 1; cycle();
    mdis_wd = 0; cycle(); idle_wr();
    check(mdis == 1'b1, "R7 clear refused", mdis, 1);
    // R10/R5: enable while visible -> no run, held in reset
    en_we = 1; en_wd = 1; cycle(); idle_wr();
    repeat (2) cycle();
    check(run == 0 && addr == 0, "R5 held in reset", addr, 0);
    // clear vis and mdis together: mdis judged against old vis
    vis_we = 1; vis_wd = 0; mdis_we = 1; mdis_wd = 0; cycle(); idle_wr();
    check(mdis == 1'b1, "R7 same-cycle clear refused", mdis, 1);
    // R9: checker restarts at 0 and wraps
    halt_a = 0;
    repeat (MEM_WORDS + 5) cycle();
    check(int'(addr) == 5, "R9 wrapped", addr, 5);

    // random phase
    for (int i = 0; i < 4000; i++) begin
      stop_a   = ($urandom % 4) != 0;
      stop_b   = ($urandom % 4) != 0;
      halt_a   = ($urandom % 5) == 0;
      halt_b   = ($urandom % 5) == 0;
      stop_req = ($urandom % 3) == 0;
      vis_we   = ($urandom % 6) == 0; vis_wd  = $urandom % 2;
      en_we    = ($urandom % 8) == 0; en_wd   = $urandom % 2;
      mdis_we  = ($urandom % 5) == 0; mdis_wd = $urandom % 2;
      cycle();
    end
    idle_wr();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule